// File: doc/BRIEF.md
# ECC-Protected Simple Dual-Port RAM

This block is a 512-word memory with one write-only port and one read-only port. Each port has its own clock, enable and address. Every stored word holds 64 data bits and 8 check bits of an extended Hamming single-error-correct, double-error-detect code. A read returns the data after correction, the stored check bits, and two status flags.

Two parameters switch the write-side encoder and the read-side decoder on or off independently, which gives three useful modes. In the standard mode the block generates and checks its own check bits. In the decode-only mode it stores check bits supplied from outside and corrects reads against them. In the encode-only mode it generates check bits on a registered parity output and returns stored words unchanged. The read outputs keep their value until the next enabled read.

Top module: `ecc_sdp_ram`

## Requirements
- R1: While reset is asserted and after it is released, until the first enabled read or write, rd_data, rd_chk, single_err, double_err and wr_chk_out are all zero.
- R2: With both encoder and decoder enabled, a write stores internally generated check bits and ignores wr_chk_in. A later read of that address returns the written data on rd_data, the generated check bits on rd_chk, and both flags low.
- R3: The check code: data bit i is given the i-th Hamming position in 3..71 that is not a power of two. Check bit j (j = 0..6) is the XOR of the data bits whose position has bit j set. Check bit 7 makes the parity of all 72 bits even. With the encoder enabled, wr_chk_out equals the check bits of wr_data one wr_clk edge after an enabled write, and it holds while wr_en is low. With the encoder disabled, wr_chk_out stays zero.
- R4: With the encoder disabled and the decoder enabled, wr_chk_in is stored as given and returned unchanged on rd_chk. A word whose stored check bits match its data reads back with both flags low.
- R5: With the decoder enabled, a single flipped bit anywhere in the 72 stored bits (data bits 0..63 or check bits 0..7) returns the original data, with single_err high and double_err low. The two flags are never high together.
- R6: With the decoder enabled, two flipped stored bits give double_err high and single_err low, and rd_data carries the stored data without correction.
- R7: With the encoder enabled and the decoder disabled, reads return the raw stored data and check bits, and both flags stay low.
- R8: A read takes one rd_clk edge: the outputs change at the edge where rd_en is high. rd_data, rd_chk and both flags hold while rd_en is low, including across writes to the address last read.
- R9: A write and a read to different addresses may occur in the same cycles on their separate clocks. Both complete correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-port clock |
| rd_clk | input | 1 | Read-port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each clock domain |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 9 | Write address |
| wr_data | input | 64 | Write data |
| wr_chk_in | input | 8 | External check bits, stored only when the encoder is disabled |
| wr_chk_out | output | 8 | Registered check bits of the last written data (zero when the encoder is disabled) |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 9 | Read address |
| rd_data | output | 64 | Read data, corrected when the decoder is enabled |
| rd_chk | output | 8 | Stored check bits of the last word read |
| single_err | output | 1 | Corrected single-bit error in the last word read |
| double_err | output | 1 | Uncorrectable double-bit error in the last word read |

## Verification
A write and a read can fall in the same cycle, because they run on separate clocks. The bench provokes this in a concurrent phase: a stream of writes to fresh upper addresses runs alongside a stream of reads from words already stored, and every read is judged against the bench's own record of those stored words. The same overlap also occurs when an address that was just read is written again while rd_en stays low. There the judgment is that the read outputs keep their earlier value. Error patterns are injected through the stored check bits of a decode-only instance. All three mode instances share the same stimulus, so one write is judged three ways.

// File: rtl/ecc_sdp_pkg.sv
package ecc_sdp_pkg;

  localparam int DATA_W  = 64;
  localparam int HAM_W   = 7;
  localparam int CHK_W   = HAM_W + 1;
  localparam int CW_W    = DATA_W + CHK_W;
  localparam int MAX_POS = DATA_W + HAM_W;

  // Hamming position of data bit idx: skip powers of two, start at 3
  function automatic int ecc_data_pos(input int idx);
    int pos;
    pos = 2;
    for (int i = 0; i <= idx; i++) begin
      pos = pos + 1;
      if ((pos & (pos - 1)) == 0) pos = pos + 1;
    end
    return pos;
  endfunction

  // Data bits that feed Hamming check bit j
  function automatic logic [DATA_W-1:0] ecc_mask(input int j);
    logic [DATA_W-1:0] m;
    int pos;
    m   = '0;
    pos = 2;
    for (int i = 0; i < DATA_W; i++) begin
      pos = pos + 1;
      if ((pos & (pos - 1)) == 0) pos = pos + 1;
      m[i] = ((pos >> j) & 1) == 1;
    end
    return m;
  endfunction

endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_sdp_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);

  logic [HAM_W-1:0] ham;

  for (genvar j = 0; j < HAM_W; j++) begin : g_ham
    localparam logic [DATA_W-1:0] MASK = ecc_mask(j);
    assign ham[j] = ^(data_i & MASK);
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_sdp_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              single_o,
  output logic              double_o
);

  logic [CHK_W-1:0]  regen;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic              in_range;
  logic [DATA_W-1:0] flip;

  ecc_encoder u_regen (
    .data_i (data_i),
    .chk_o  (regen)
  );

  assign syn      = regen[HAM_W-1:0] ^ chk_i[HAM_W-1:0];
  // total parity of the stored 72 bits, folded through the regenerated bits
  assign odd      = regen[CHK_W-1] ^ chk_i[CHK_W-1] ^ (^syn);
  assign in_range = (int'(syn) <= MAX_POS);

  always_comb begin
    single_o = 1'b0;
    double_o = 1'b0;
    if (odd) begin
      if (in_range) single_o = 1'b1;
      else          double_o = 1'b1;
    end else if (syn != '0) begin
      double_o = 1'b1;
    end
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int POS = ecc_data_pos(i);
    assign flip[i] = single_o && (syn == HAM_W'(POS));
  end

  assign data_o = data_i ^ flip;

endmodule

// File: rtl/ecc_sdp_array.sv
module ecc_sdp_array
  import ecc_sdp_pkg::*;
#(
  parameter int ADDR_W = 9,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW_W-1:0]   wr_word,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CW_W-1:0]   rd_word
);

  logic [CW_W-1:0] mem [DEPTH];
  logic [CW_W-1:0] rd_word_q;
  logic [CW_W-1:0] rd_word_d;

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      mem[wr_addr] <= wr_word;
    end
  end

  always_comb begin
    rd_word_d = rd_word_q;
    if (rd_en) rd_word_d = mem[rd_addr];
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rd_word_q <= '0;
    end else begin
      rd_word_q <= rd_word_d;
    end
  end

  assign rd_word = rd_word_q;

endmodule

// File: rtl/ecc_sdp_ram.sv
module ecc_sdp_ram
  import ecc_sdp_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter bit ENC_EN = 1'b1,
  parameter bit DEC_EN = 1'b1
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHK_W-1:0]  wr_chk_in,
  output logic [CHK_W-1:0]  wr_chk_out,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CHK_W-1:0]  rd_chk,
  output logic              single_err,
  output logic              double_err
);

  logic            wr_rst_n;
  logic            rd_rst_n;
  logic [CHK_W-1:0] store_chk;
  logic [CW_W-1:0]  rd_word;

  ecc_rst_sync u_wr_sync (.clk(wr_clk), .rst_n_i(rst_n), .rst_n_o(wr_rst_n));
  ecc_rst_sync u_rd_sync (.clk(rd_clk), .rst_n_i(rst_n), .rst_n_o(rd_rst_n));

  if (ENC_EN) begin : g_enc
    logic [CHK_W-1:0] gen_chk;
    logic [CHK_W-1:0] par_q;
    logic [CHK_W-1:0] par_d;
    logic             unused_chk_in;

    ecc_encoder u_enc (
      .data_i (wr_data),
      .chk_o  (gen_chk)
    );

    assign store_chk     = gen_chk;
    assign unused_chk_in = ^wr_chk_in;

    always_comb begin
      par_d = par_q;
      if (wr_en) par_d = gen_chk;
    end

    always_ff @(posedge wr_clk or negedge wr_rst_n) begin
      if (!wr_rst_n) begin
        par_q <= '0;
      end else begin
        par_q <= par_d;
      end
    end

    assign wr_chk_out = par_q;
  end else begin : g_noenc
    assign store_chk  = wr_chk_in;
    assign wr_chk_out = '0;
  end

  ecc_sdp_array #(.ADDR_W(ADDR_W)) u_array (
    .wr_clk   (wr_clk),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_word  ({store_chk, wr_data}),
    .rd_clk   (rd_clk),
    .rd_rst_n (rd_rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_word  (rd_word)
  );

  assign rd_chk = rd_word[CW_W-1:DATA_W];

  if (DEC_EN) begin : g_dec
    ecc_decoder u_dec (
      .data_i   (rd_word[DATA_W-1:0]),
      .chk_i    (rd_word[CW_W-1:DATA_W]),
      .data_o   (rd_data),
      .single_o (single_err),
      .double_o (double_err)
    );
  end else begin : g_nodec
    assign rd_data    = rd_word[DATA_W-1:0];
    assign single_err = 1'b0;
    assign double_err = 1'b0;
  end

endmodule

// File: rtl/ecc_sdp_ram_chk.sv
module ecc_sdp_ram_chk #(
  parameter bit ENC_EN = 1'b1,
  parameter bit DEC_EN = 1'b1
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [63:0] rd_data,
  input logic [7:0]  rd_chk,
  input logic        single_err,
  input logic        double_err,
  input logic [7:0]  wr_chk_out
);

  p_flag_excl_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !(single_err && double_err));

  p_rd_hold_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_en |=> $stable({rd_data, rd_chk, single_err, double_err}));

  p_par_hold_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_chk_out));

  p_par_zero_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !ENC_EN |-> wr_chk_out == 8'h00);

  p_noflag_r7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !DEC_EN |-> (!single_err && !double_err));

endmodule

bind ecc_sdp_ram ecc_sdp_ram_chk #(.ENC_EN(ENC_EN), .DEC_EN(DEC_EN)) u_chk (
  .wr_clk     (wr_clk),
  .rd_clk     (rd_clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rd_chk     (rd_chk),
  .single_err (single_err),
  .double_err (double_err),
  .wr_chk_out (wr_chk_out)
);

// File: tb/ecc_sdp_ram_tb.sv
module ecc_sdp_ram_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        wr_clk, rd_clk, rst_n;
  logic        wr_en, rd_en;
  logic [8:0]  wr_addr, rd_addr;
  logic [63:0] wr_data;
  logic [7:0]  wr_chk_in;

  logic [7:0]  s_par, d_par, e_par;
  logic [63:0] s_data, d_data, e_data;
  logic [7:0]  s_chk, d_chk, e_chk;
  logic        s_se, s_de, d_se, d_de, e_se, e_de;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [63:0] sb_d  [512];
  logic [63:0] sb_dc [512];
  logic [7:0]  sb_c  [512];
  int          sb_n  [512];

  initial wr_clk = 0;
  always #2.5 wr_clk = ~wr_clk;
  initial rd_clk = 0;
  always #3.5 rd_clk = ~rd_clk;

  ecc_sdp_ram #(.ENC_EN(1'b1), .DEC_EN(1'b1)) u_dut (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_chk_in(wr_chk_in), .wr_chk_out(s_par), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(s_data), .rd_chk(s_chk), .single_err(s_se), .double_err(s_de));

  ecc_sdp_ram #(.ENC_EN(1'b0), .DEC_EN(1'b1)) u_dec (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_chk_in(wr_chk_in), .wr_chk_out(d_par), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(d_data), .rd_chk(d_chk), .single_err(d_se), .double_err(d_de));

  ecc_sdp_ram #(.ENC_EN(1'b1), .DEC_EN(1'b0)) u_enc (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_chk_in(wr_chk_in), .wr_chk_out(e_par), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(e_data), .rd_chk(e_chk), .single_err(e_se), .double_err(e_de));

  // Reference check bits: build the codeword in Hamming order, then fold positions
  function automatic logic [7:0] tb_chk(input logic [63:0] d);
    logic [127:0] cw;
    logic [7:0]   c;
    int           k;
    cw = '0;
    c  = '0;
    k  = 0;
    for (int p = 1; p <= 71; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int j = 0; j < 7; j++)
      for (int p = 1; p <= 71; p++)
        if (((p >> j) & 1) == 1) c[j] = c[j] ^ cw[p];
    c[7] = ^{d, c[6:0]};
    return c;
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [8:0] a, input logic [63:0] d, input int nerr,
                            input int b0, input int b1);
    logic [71:0] cw;
    cw = {tb_chk(d), d};
    if (nerr >= 1) cw[b0] = ~cw[b0];
    if (nerr >= 2) cw[b1] = ~cw[b1];
    sb_d[a]  = d;
    sb_dc[a] = cw[63:0];
    sb_c[a]  = cw[71:64];
    sb_n[a]  = nerr;
    @(negedge wr_clk);
    wr_en     = 1'b1;
    wr_addr   = a;
    wr_data   = cw[63:0];
    wr_chk_in = cw[71:64];
    @(negedge wr_clk);
    wr_en = 1'b0;
    check("R3 std parity out", 72'(s_par), 72'(tb_chk(cw[63:0])));
    check("R3 enc parity out", 72'(e_par), 72'(tb_chk(cw[63:0])));
    check("R3 dec parity zero", 72'(d_par), 72'h0);
  endtask

  task automatic read_word(input logic [8:0] a);
    logic [63:0] dc;
    @(negedge rd_clk);
    rd_en   = 1'b1;
    rd_addr = a;
    @(negedge rd_clk);
    rd_en = 1'b0;
    dc = sb_dc[a];
    check("R2 std data/chk", {s_chk, s_data}, {tb_chk(dc), dc});
    check("R2 std flags", 72'({s_se, s_de}), 72'h0);
    check("R7 enc raw data/chk", {e_chk, e_data}, {tb_chk(dc), dc});
    check("R7 enc flags", 72'({e_se, e_de}), 72'h0);
    check("R4 dec chk as given", 72'(d_chk), 72'(sb_c[a]));
    case (sb_n[a])
      0: begin
        check("R4 dec clean data", 72'(d_data), 72'(sb_d[a]));
        check("R4 dec clean flags", 72'({d_se, d_de}), 72'h0);
      end
      1: begin
        check("R5 dec corrected data", 72'(d_data), 72'(sb_d[a]));
        check("R5 dec single flag", 72'({d_se, d_de}), 72'h2);
      end
      default: begin
        check("R6 dec raw data", 72'(d_data), 72'(dc));
        check("R6 dec double flag", 72'({d_se, d_de}), 72'h1);
      end
    endcase
  endtask

  task automatic pick2(output int b0, output int b1);
    b0 = int'($urandom % 72);
    b1 = (b0 + 1 + int'($urandom % 71)) % 72;
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [71:0] held;
    logic [7:0]  par_held;
    int b0, b1, ne;
    void'($urandom(32'h00C0FFEE));
    wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0; wr_chk_in = '0;
    rst_n = 0;
    #20;
    check("R1 reset read outputs", {s_chk, s_data}, 72'h0);
    check("R1 reset flags", 72'({s_se, s_de, d_se, d_de, e_se, e_de}), 72'h0);
    check("R1 reset parity", 72'({s_par, d_par, e_par}), 72'h0);
    rst_n = 1;
    repeat (5) @(negedge rd_clk);
    check("R1 after release", {d_chk, d_data}, 72'h0);

    // directed corners
    write_word(9'd0,   64'h0, 0, 0, 0);
    write_word(9'd511, '1,    0, 0, 0);
    write_word(9'd1, 64'h0123_4567_89AB_CDEF, 1, 0,  0);
    write_word(9'd2, 64'hFEDC_BA98_7654_3210, 1, 63, 0);
    write_word(9'd3, 64'hA5A5_5A5A_F00F_0FF0, 1, 64, 0);
    write_word(9'd4, 64'h1111_2222_3333_4444, 1, 71, 0);
    write_word(9'd5, 64'hDEAD_BEEF_CAFE_F00D, 2, 0,  1);
    write_word(9'd6, 64'h0F0F_0F0F_0F0F_0F0F, 2, 5,  70);
    write_word(9'd7, 64'h8000_0000_0000_0001, 2, 64, 71);
    for (int a = 0; a < 8; a++) read_word(9'(a));
    read_word(9'd511);

    // R3 hold: parity output unchanged while wr_en low
    par_held = s_par;
    repeat (4) @(negedge wr_clk);
    check("R3 parity hold", 72'(s_par), 72'(par_held));

    // R8 latency and hold across a write to the address just read
    read_word(9'd1);
    held = {s_chk, s_data};
    @(negedge rd_clk);
    rd_en = 1'b1; rd_addr = 9'd2;
    #1;
    check("R8 no change before edge", {s_chk, s_data}, held);
    @(negedge rd_clk);
    rd_en = 1'b0;
    check("R8 one-edge latency", {s_chk, s_data}, {tb_chk(sb_dc[2]), sb_dc[2]});
    held = {d_chk, d_data};
    write_word(9'd2, 64'h5555_AAAA_5555_AAAA, 0, 0, 0);
    repeat (3) @(negedge rd_clk);
    check("R8 hold across write", {d_chk, d_data}, held);
    read_word(9'd2);

    // random words with 0, 1 or 2 injected errors
    for (int k = 0; k < 120; k++) begin
      pick2(b0, b1);
      ne = int'($urandom % 3);
      write_word(9'(8 + k), {$urandom, $urandom}, ne, b0, b1);
      read_word(9'(8 + k));
    end

    // R9 concurrent write and read streams on disjoint addresses
    fork
      begin
        for (int k = 0; k < 32; k++) begin
          int c0, c1;
          pick2(c0, c1);
          write_word(9'(256 + k), {$urandom, $urandom}, k % 3, c0, c1);
        end
      end
      begin
        for (int k = 0; k < 32; k++) read_word(9'(8 + ((k * 37) % 120)));
      end
    join
    for (int k = 0; k < 32; k++) read_word(9'(256 + k));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule